// File: doc/BRIEF.md
# Shadow Protocol Address Receiver

This block lets a test bus controller pick one secondary scan port out of many that share a multidrop test access bus. It tracks the bus's 16-state TAP controller from the mode-select line. While that controller rests in one of its four parking states, the block listens on the serial data line for an address frame. The frame is a start marker, ten address bits sent most significant bit first and a stop marker. Every one of these symbols travels as a pair of line bits.

When a complete, well-formed frame arrives, the received address is checked against three global codes and against the block's own strapped address. The result is a one-cycle command to the switch logic around the block: connect, disconnect, reset or multicast. Before the connect command, the block proves that it was selected by sending its own address back on the serial return line in the same framing. All state changes on the rising edge of the test clock. The test reset line clears the block asynchronously.

Top module: `shadow_addr_rx`

## Requirements
- R1: An active-low `rstN` puts the TAP tracker in Test-Logic-Reset and drives every command output and `ackEn` low. After reset the tracker follows `tms` through the standard 16-state graph, so five rising edges with `tms` high reach Test-Logic-Reset from any state.
- R2: Line-bit pairs decode as follows. `11` is a start marker, `01` is address bit 0, `10` is address bit 1 and `00` is a stop marker. A frame is one start pair, then ADDR_W address pairs sent most significant bit first, then one stop pair: 2*ADDR_W+4 bits in all. The acknowledgement uses this same framing.
- R3: `tdi` is sampled only on edges where the tracker, before the edge, is in Test-Logic-Reset, Run-Test/Idle, Pause-DR or Pause-IR. If the tracker leaves those states partway through a frame, the frame is dropped. A frame sent in Shift-DR or Shift-IR produces no command and no acknowledgement.
- R4: A data pair of `00` or `11`, or a stop pair other than `00`, drops the frame with no command and no acknowledgement.
- R5: If the received address equals `myAddr` and is not a global code, `ackEn` rises in the cycle after the edge that samples the last stop bit. It stays high for 2*ADDR_W+4 cycles while `ackOut` carries a frame of the block's own address. `connectReq` then pulses for one cycle in the cycle after the last acknowledgement bit.
- R6: Any other non-global address pulses `disconnectReq` in the cycle after the last stop bit and sends no acknowledgement.
- R7: The all-ones code (0x3FF) pulses `disconnectReq` with the same timing as R6.
- R8: The all-ones-minus-one code (0x3FE) pulses `resetReq` with the same timing as R6.
- R9: The all-ones-minus-two code (0x3FD) pulses `multicastReq` with the same timing as R6, but only when its last stop bit is sampled in Pause-DR or Pause-IR. In any other state it produces nothing.
- R10: The global codes take precedence over `myAddr`. A block strapped to a global code reacts to that code as a global code.
- R11: While the acknowledgement is being sent, `tdi` is ignored, so no frame sent in that window is decoded.
- R12: Command outputs are one-cycle pulses, and no two are high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Primary test clock; every register uses its rising edge |
| rstN | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Primary mode-select line followed by the TAP tracker |
| tdi | input | 1 | Primary serial data line carrying address frames |
| myAddr | input | ADDR_W | Strapped local address |
| ackEn | output | 1 | High while the acknowledgement frame is driven |
| ackOut | output | 1 | Serial acknowledgement bit; low when `ackEn` is low |
| connectReq | output | 1 | One-cycle connect command |
| disconnectReq | output | 1 | One-cycle disconnect command |
| resetReq | output | 1 | One-cycle reset command |
| multicastReq | output | 1 | One-cycle multicast command |

## Verification
Disconnect, reset and multicast are registered on the same edge that samples the second stop bit, so they are due exactly one cycle after that bit is driven. Acknowledgement bit i appears i+1 cycles after that bit, and connect follows the last acknowledgement bit by one cycle. The bench's behavioural model works out the expected value of every output for the cycle after each rising edge, and the bench compares at the falling edge, when all of those values have settled. Each scenario also counts command pulses and acknowledgement cycles over an idle tail long enough to cover the latest result, and checks those totals against the requirement.

// File: rtl/shadow_rx_pkg.sv
package shadow_rx_pkg;

  typedef enum logic [3:0] {
    TAP_TLR, TAP_RTI, TAP_SEL_DR, TAP_CAP_DR, TAP_SHIFT_DR, TAP_EXIT1_DR,
    TAP_PAUSE_DR, TAP_EXIT2_DR, TAP_UPD_DR, TAP_SEL_IR, TAP_CAP_IR,
    TAP_SHIFT_IR, TAP_EXIT1_IR, TAP_PAUSE_IR, TAP_EXIT2_IR, TAP_UPD_IR
  } tapState_e;

  typedef enum logic [1:0] {
    RX_IDLE, RX_DATA, RX_STOP, RX_ACK
  } rxState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic clearRx;   // start of a new frame
    logic capFirst;  // hold first bit of a pair
    logic shiftBit;  // accept a decoded address bit
    logic ackStart;  // load acknowledgement
    logic ackStep;   // advance acknowledgement
  } rxStrobes_t;

endpackage

// File: rtl/tap_tracker.sv
module tap_tracker
  import shadow_rx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      tms,
  output tapState_e tapState
);

  tapState_e nextState;

  always_comb begin
    nextState = tapState;
    unique case (tapState)
      TAP_TLR:      nextState = tms ? TAP_TLR      : TAP_RTI;
      TAP_RTI:      nextState = tms ? TAP_SEL_DR   : TAP_RTI;
      TAP_SEL_DR:   nextState = tms ? TAP_SEL_IR   : TAP_CAP_DR;
      TAP_CAP_DR:   nextState = tms ? TAP_EXIT1_DR : TAP_SHIFT_DR;
      TAP_SHIFT_DR: nextState = tms ? TAP_EXIT1_DR : TAP_SHIFT_DR;
      TAP_EXIT1_DR: nextState = tms ? TAP_UPD_DR   : TAP_PAUSE_DR;
      TAP_PAUSE_DR: nextState = tms ? TAP_EXIT2_DR : TAP_PAUSE_DR;
      TAP_EXIT2_DR: nextState = tms ? TAP_UPD_DR   : TAP_SHIFT_DR;
      TAP_UPD_DR:   nextState = tms ? TAP_SEL_DR   : TAP_RTI;
      TAP_SEL_IR:   nextState = tms ? TAP_TLR      : TAP_CAP_IR;
      TAP_CAP_IR:   nextState = tms ? TAP_EXIT1_IR : TAP_SHIFT_IR;
      TAP_SHIFT_IR: nextState = tms ? TAP_EXIT1_IR : TAP_SHIFT_IR;
      TAP_EXIT1_IR: nextState = tms ? TAP_UPD_IR   : TAP_PAUSE_IR;
      TAP_PAUSE_IR: nextState = tms ? TAP_EXIT2_IR : TAP_PAUSE_IR;
      TAP_EXIT2_IR: nextState = tms ? TAP_UPD_IR   : TAP_SHIFT_IR;
      TAP_UPD_IR:   nextState = tms ? TAP_SEL_DR   : TAP_RTI;
      default:      nextState = TAP_TLR;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tapState <= TAP_TLR;
    else       tapState <= nextState;
  end

  // R1: with tms held high, Test-Logic-Reset is never left
  assert_tlr_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    (tapState == TAP_TLR && tms) |=> tapState == TAP_TLR);

endmodule

// File: rtl/shadow_rx_dp.sv
module shadow_rx_dp
  import shadow_rx_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tdi,
  input  logic [ADDR_W-1:0] myAddr,
  input  rxStrobes_t        stb,
  output logic              firstHalf,
  output logic              dataLast,
  output logic              ackLast,
  output logic              ackBit,
  output logic              isDsa,
  output logic              isRsa,
  output logic              isTsa,
  output logic              isMatch
);

  localparam int FRAME_LEN = 2 * ADDR_W + 4;
  localparam int ACK_CNT_W = $clog2(FRAME_LEN);
  localparam int BIT_CNT_W = $clog2(ADDR_W + 1);
  localparam logic [ADDR_W-1:0] CODE_DSA = '1;
  localparam logic [ADDR_W-1:0] CODE_RSA = CODE_DSA - ADDR_W'(1);
  localparam logic [ADDR_W-1:0] CODE_TSA = CODE_DSA - ADDR_W'(2);
  localparam logic [ACK_CNT_W-1:0] ACK_DATA_LO = ACK_CNT_W'(2);
  localparam logic [ACK_CNT_W-1:0] ACK_STOP_LO = ACK_CNT_W'(FRAME_LEN - 2);
  localparam logic [ACK_CNT_W-1:0] ACK_END     = ACK_CNT_W'(FRAME_LEN - 1);

  logic [ADDR_W-1:0]    rxShift;
  logic [BIT_CNT_W-1:0] bitCnt;
  logic [ACK_CNT_W-1:0] ackCnt;
  logic [ADDR_W-1:0]    ackShift;
  logic                 ackInData;

  assign ackInData = (ackCnt >= ACK_DATA_LO) && (ackCnt < ACK_STOP_LO);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      firstHalf <= 1'b0;
      rxShift   <= '0;
      bitCnt    <= '0;
      ackCnt    <= '0;
      ackShift  <= '0;
    end else begin
      if (stb.capFirst) firstHalf <= tdi;
      if (stb.clearRx) begin
        bitCnt <= '0;
      end else if (stb.shiftBit) begin
        rxShift <= {rxShift[ADDR_W-2:0], firstHalf};
        bitCnt  <= bitCnt + BIT_CNT_W'(1);
      end
      if (stb.ackStart) begin
        ackCnt   <= '0;
        ackShift <= myAddr;
      end else if (stb.ackStep) begin
        ackCnt <= ackCnt + ACK_CNT_W'(1);
        if (ackInData && ackCnt[0]) ackShift <= {ackShift[ADDR_W-2:0], 1'b0};
      end
    end
  end

  assign dataLast = (bitCnt == BIT_CNT_W'(ADDR_W - 1));
  assign ackLast  = (ackCnt == ACK_END);
  assign isDsa    = (rxShift == CODE_DSA);
  assign isRsa    = (rxShift == CODE_RSA);
  assign isTsa    = (rxShift == CODE_TSA);
  assign isMatch  = (rxShift == myAddr);

  always_comb begin
    if (ackCnt < ACK_DATA_LO)       ackBit = 1'b1;
    else if (ackCnt >= ACK_STOP_LO) ackBit = 1'b0;
    else                            ackBit = ackShift[ADDR_W-1] ^ ackCnt[0];
  end

  // R2: acknowledgement frame opens with a start-marker bit
  assert_ack_lead_R2: assert property (@(posedge clk) disable iff (!rstN)
    stb.ackStart |=> ackBit);

  // R2: the bit counter never runs past one frame's worth of address bits
  assert_bitcnt_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= BIT_CNT_W'(ADDR_W));

endmodule

// File: rtl/shadow_rx_ctrl.sv
module shadow_rx_ctrl
  import shadow_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tdi,
  input  tapState_e  tapState,
  input  logic       firstHalf,
  input  logic       dataLast,
  input  logic       ackLast,
  input  logic       isDsa,
  input  logic       isRsa,
  input  logic       isTsa,
  input  logic       isMatch,
  output rxStrobes_t stb,
  output logic       ackEn,
  output logic       connectReq,
  output logic       disconnectReq,
  output logic       resetReq,
  output logic       multicastReq
);

  rxState_e rxState, nState;
  logic     sawOne, nSaw;
  logic     phase, nPhase;
  logic     nConn, nDisc, nRst, nMc;
  logic     stable, inPause;

  assign inPause = (tapState == TAP_PAUSE_DR) || (tapState == TAP_PAUSE_IR);
  assign stable  = inPause || (tapState == TAP_TLR) || (tapState == TAP_RTI);

  always_comb begin
    nState = rxState;
    nSaw   = 1'b0;
    nPhase = phase;
    nConn  = 1'b0;
    nDisc  = 1'b0;
    nRst   = 1'b0;
    nMc    = 1'b0;
    stb    = '0;
    unique case (rxState)
      RX_IDLE: begin
        if (stable) begin
          if (sawOne && tdi) begin
            nState      = RX_DATA;
            nPhase      = 1'b0;
            stb.clearRx = 1'b1;
          end else begin
            nSaw = tdi;
          end
        end
      end
      RX_DATA: begin
        if (!stable) begin
          nState = RX_IDLE;
        end else if (!phase) begin
          stb.capFirst = 1'b1;
          nPhase       = 1'b1;
        end else begin
          nPhase = 1'b0;
          if (tdi != firstHalf) begin
            stb.shiftBit = 1'b1;
            if (dataLast) nState = RX_STOP;
          end else begin
            nState = RX_IDLE;
          end
        end
      end
      RX_STOP: begin
        if (!stable) begin
          nState = RX_IDLE;
        end else if (!phase) begin
          stb.capFirst = 1'b1;
          nPhase       = 1'b1;
        end else begin
          nPhase = 1'b0;
          nState = RX_IDLE;
          if (!tdi && !firstHalf) begin
            if (isDsa)      nDisc = 1'b1;
            else if (isRsa) nRst  = 1'b1;
            else if (isTsa) nMc   = inPause;
            else if (isMatch) begin
              nState       = RX_ACK;
              stb.ackStart = 1'b1;
            end else        nDisc = 1'b1;
          end
        end
      end
      RX_ACK: begin
        stb.ackStep = 1'b1;
        if (ackLast) begin
          nState = RX_IDLE;
          nConn  = 1'b1;
        end
      end
      default: nState = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxState       <= RX_IDLE;
      sawOne        <= 1'b0;
      phase         <= 1'b0;
      connectReq    <= 1'b0;
      disconnectReq <= 1'b0;
      resetReq      <= 1'b0;
      multicastReq  <= 1'b0;
    end else begin
      rxState       <= nState;
      sawOne        <= nSaw;
      phase         <= nPhase;
      connectReq    <= nConn;
      disconnectReq <= nDisc;
      resetReq      <= nRst;
      multicastReq  <= nMc;
    end
  end

  assign ackEn = (rxState == RX_ACK);

  // R12: never two commands at once
  assert_one_cmd_R12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({connectReq, disconnectReq, resetReq, multicastReq}));

  // R12: a command is gone one cycle later
  assert_cmd_pulse_R12: assert property (@(posedge clk) disable iff (!rstN)
    (connectReq || disconnectReq || resetReq || multicastReq)
      |=> !(connectReq || disconnectReq || resetReq || multicastReq));

  // R3: leaving the parking states drops a frame in progress
  assert_abort_unstable_R3: assert property (@(posedge clk) disable iff (!rstN)
    ((rxState == RX_DATA || rxState == RX_STOP) && !stable) |=> rxState == RX_IDLE);

  // R5: connect only follows an acknowledgement
  assert_connect_after_ack_R5: assert property (@(posedge clk) disable iff (!rstN)
    connectReq |-> $past(ackEn));

  // R9: multicast only when the stop was seen in a pause state
  assert_mc_in_pause_R9: assert property (@(posedge clk) disable iff (!rstN)
    multicastReq |-> $past(inPause));

endmodule

// File: rtl/shadow_addr_rx.sv
module shadow_addr_rx
  import shadow_rx_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tms,
  input  logic              tdi,
  input  logic [ADDR_W-1:0] myAddr,
  output logic              ackEn,
  output logic              ackOut,
  output logic              connectReq,
  output logic              disconnectReq,
  output logic              resetReq,
  output logic              multicastReq
);

  tapState_e  tapState;
  rxStrobes_t stb;
  logic firstHalf, dataLast, ackLast, ackBit;
  logic isDsa, isRsa, isTsa, isMatch;

  tap_tracker u_tap (
    .clk      (clk),
    .rstN     (rstN),
    .tms      (tms),
    .tapState (tapState)
  );

  shadow_rx_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .tdi       (tdi),
    .myAddr    (myAddr),
    .stb       (stb),
    .firstHalf (firstHalf),
    .dataLast  (dataLast),
    .ackLast   (ackLast),
    .ackBit    (ackBit),
    .isDsa     (isDsa),
    .isRsa     (isRsa),
    .isTsa     (isTsa),
    .isMatch   (isMatch)
  );

  shadow_rx_ctrl u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .tdi           (tdi),
    .tapState      (tapState),
    .firstHalf     (firstHalf),
    .dataLast      (dataLast),
    .ackLast       (ackLast),
    .isDsa         (isDsa),
    .isRsa         (isRsa),
    .isTsa         (isTsa),
    .isMatch       (isMatch),
    .stb           (stb),
    .ackEn         (ackEn),
    .connectReq    (connectReq),
    .disconnectReq (disconnectReq),
    .resetReq      (resetReq),
    .multicastReq  (multicastReq)
  );

  assign ackOut = ackEn & ackBit;

endmodule

// File: tb/shadow_addr_rx_bench.sv
`timescale 1ns/1ps
module shadow_addr_rx_bench;

  localparam int AW = 10;
  localparam int FL = 2 * AW + 4;
  localparam logic [AW-1:0] HOME = 10'h2A5;

  // bench-side TAP state numbering
  localparam int S_TLR = 0, S_RTI = 1, S_SDR = 2, S_CDR = 3, S_SHDR = 4, S_E1DR = 5,
                 S_PDR = 6, S_E2DR = 7, S_UDR = 8, S_SIR = 9, S_CIR = 10, S_SHIR = 11,
                 S_E1IR = 12, S_PIR = 13, S_E2IR = 14, S_UIR = 15;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tms = 1'b1;
  logic tdi = 1'b0;
  logic [AW-1:0] myAddr = HOME;
  logic ackEn, ackOut, connectReq, disconnectReq, resetReq, multicastReq;

  int nChecks = 0;
  int nFails = 0;
  bit modelOn = 1'b0;

  always #10 clk = ~clk;

  shadow_addr_rx #(.ADDR_W(AW)) u_shadow_addr_rx (
    .clk(clk), .rstN(rstN), .tms(tms), .tdi(tdi), .myAddr(myAddr),
    .ackEn(ackEn), .ackOut(ackOut), .connectReq(connectReq),
    .disconnectReq(disconnectReq), .resetReq(resetReq), .multicastReq(multicastReq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int nextTap(input int s, input bit m);
    case (s)
      S_TLR:  return m ? S_TLR  : S_RTI;
      S_RTI:  return m ? S_SDR  : S_RTI;
      S_SDR:  return m ? S_SIR  : S_CDR;
      S_CDR:  return m ? S_E1DR : S_SHDR;
      S_SHDR: return m ? S_E1DR : S_SHDR;
      S_E1DR: return m ? S_UDR  : S_PDR;
      S_PDR:  return m ? S_E2DR : S_PDR;
      S_E2DR: return m ? S_UDR  : S_SHDR;
      S_UDR:  return m ? S_SDR  : S_RTI;
      S_SIR:  return m ? S_TLR  : S_CIR;
      S_CIR:  return m ? S_E1IR : S_SHIR;
      S_SHIR: return m ? S_E1IR : S_SHIR;
      S_E1IR: return m ? S_UIR  : S_PIR;
      S_PIR:  return m ? S_E2IR : S_PIR;
      S_E2IR: return m ? S_UIR  : S_SHIR;
      default: return m ? S_SDR : S_RTI;
    endcase
  endfunction

  function automatic bit frameBit(input int i, input logic [AW-1:0] a);
    int k;
    if (i < 2) return 1'b1;
    if (i >= FL - 2) return 1'b0;
    k = AW - 1 - (i - 2) / 2;
    return ((i - 2) % 2) ? ~a[k] : a[k];
  endfunction

  // ---------------- behavioural reference model ----------------
  int mTap;
  bit q[$];
  int ackIdx;
  logic [AW-1:0] ackAddr;
  bit eAckEn, eAckOut, eConn, eDisc, eRst, eMc;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mTap = S_TLR; q.delete(); ackIdx = -1;
      eAckEn = 0; eAckOut = 0; eConn = 0; eDisc = 0; eRst = 0; eMc = 0;
    end else begin
      int n;
      logic [AW-1:0] ra;
      eConn = 0; eDisc = 0; eRst = 0; eMc = 0;
      if (ackIdx >= 0) begin
        if (ackIdx == FL - 1) begin ackIdx = -1; eConn = 1; end
        else ackIdx++;
      end else if (!(mTap == S_TLR || mTap == S_RTI || mTap == S_PDR || mTap == S_PIR)) begin
        q.delete();
      end else begin
        q.push_back(tdi);
        n = q.size();
        if (n == 1 && !q[0]) q.delete();
        else if (n == 2 && !q[1]) q.delete();
        else if (n >= 4 && n % 2 == 0) begin
          if (n < FL) begin
            if (q[n-2] == q[n-1]) q.delete();
          end else begin
            if (!q[FL-2] && !q[FL-1]) begin
              for (int k = 0; k < AW; k++) ra[AW-1-k] = q[2 + 2*k];
              if (ra == 10'h3FF) eDisc = 1;
              else if (ra == 10'h3FE) eRst = 1;
              else if (ra == 10'h3FD) eMc = (mTap == S_PDR || mTap == S_PIR);
              else if (ra == myAddr) begin ackIdx = 0; ackAddr = myAddr; end
              else eDisc = 1;
            end
            q.delete();
          end
        end
      end
      eAckEn = (ackIdx >= 0);
      eAckOut = eAckEn ? frameBit(ackIdx, ackAddr) : 1'b0;
      mTap = nextTap(mTap, tms);
    end
  end

  // ---------------- monitor: compare every cycle, count events ----------------
  int cConn, cDisc, cRst, cMc, cAck, cMulti, cDouble;
  bit prevAny = 1'b0;

  always @(negedge clk) begin
    if (modelOn && rstN) begin
      int nHigh;
      bit ok;
      ok = (ackEn === eAckEn) && (ackOut === eAckOut) && (connectReq === eConn) &&
           (disconnectReq === eDisc) && (resetReq === eRst) && (multicastReq === eMc);
      nChecks++;
      if (!ok) begin
        nFails++;
        if (ackEn !== eAckEn || ackOut !== eAckOut)
          $display("FAIL R2/R5 ack actual=%0b%0b expected=%0b%0b", ackEn, ackOut, eAckEn, eAckOut);
        if (connectReq !== eConn)
          $display("FAIL R5 connect actual=%0b expected=%0b", connectReq, eConn);
        if (disconnectReq !== eDisc)
          $display("FAIL R6 disconnect actual=%0b expected=%0b", disconnectReq, eDisc);
        if (resetReq !== eRst)
          $display("FAIL R8 reset actual=%0b expected=%0b", resetReq, eRst);
        if (multicastReq !== eMc)
          $display("FAIL R9 multicast actual=%0b expected=%0b", multicastReq, eMc);
      end
      cConn += connectReq; cDisc += disconnectReq; cRst += resetReq; cMc += multicastReq;
      cAck += ackEn;
      nHigh = connectReq + disconnectReq + resetReq + multicastReq;
      if (nHigh > 1) cMulti++;
      if (prevAny && nHigh > 0) cDouble++;
      prevAny = (nHigh > 0);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step(input bit m, input bit d);
    @(negedge clk); #1;
    tms = m; tdi = d;
    @(posedge clk);
  endtask

  task automatic clearCounts();
    cConn = 0; cDisc = 0; cRst = 0; cMc = 0; cAck = 0;
  endtask

  task automatic sendFrame(input logic [AW-1:0] a, input bit m);
    for (int i = 0; i < FL; i++) step(m, frameBit(i, a));
  endtask

  task automatic idle(input int n, input bit m);
    for (int i = 0; i < n; i++) step(m, 1'b0);
    @(negedge clk); #2;
  endtask

  task automatic expectCounts(input string req, input int conn, input int disc,
                              input int rst, input int mc, input int ack);
    chk(cConn == conn, {req, " connect count"}, cConn, conn);
    chk(cDisc == disc, {req, " disconnect count"}, cDisc, disc);
    chk(cRst == rst, {req, " reset count"}, cRst, rst);
    chk(cMc == mc, {req, " multicast count"}, cMc, mc);
    chk(cAck == ack, {req, " ack cycles"}, cAck, ack);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(20 * 20000);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  // ---------------- scenarios ----------------
  initial begin
    cMulti = 0; cDouble = 0;
    clearCounts();
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1; modelOn = 1'b1;
    @(negedge clk); #2;
    // R1: quiet outputs after reset
    chk({ackEn, ackOut, connectReq, disconnectReq, resetReq, multicastReq} == 6'b0,
        "R1 outputs after reset",
        {ackEn, ackOut, connectReq, disconnectReq, resetReq, multicastReq}, 0);

    // R3: frame accepted in Test-Logic-Reset (tms held high)
    clearCounts(); sendFrame(HOME, 1'b1); idle(30, 1'b1);
    expectCounts("R3 TLR match", 1, 0, 0, 0, FL);

    step(1'b0, 1'b0); // to Run-Test/Idle
    // R5, R2: match in Run-Test/Idle
    clearCounts(); sendFrame(HOME, 1'b0); idle(30, 1'b0);
    expectCounts("R5 RTI match", 1, 0, 0, 0, FL);

    // R6: mismatch
    clearCounts(); sendFrame(10'h155, 1'b0); idle(30, 1'b0);
    expectCounts("R6 mismatch", 0, 1, 0, 0, 0);

    // R7: global disconnect
    clearCounts(); sendFrame(10'h3FF, 1'b0); idle(30, 1'b0);
    expectCounts("R7 global disconnect", 0, 1, 0, 0, 0);

    // R8: global reset
    clearCounts(); sendFrame(10'h3FE, 1'b0); idle(30, 1'b0);
    expectCounts("R8 global reset", 0, 0, 1, 0, 0);

    // R9: test-sync outside a pause state is ignored
    clearCounts(); sendFrame(10'h3FD, 1'b0); idle(30, 1'b0);
    expectCounts("R9 tsa in RTI", 0, 0, 0, 0, 0);

    // R9: test-sync in Pause-DR
    step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b1, 1'b0); step(1'b0, 1'b0);
    clearCounts(); sendFrame(10'h3FD, 1'b0); idle(30, 1'b0);
    expectCounts("R9 tsa in PauseDR", 0, 0, 0, 1, 0);

    // back to RTI, then into Shift-DR: R3 frame ignored
    step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b0, 1'b0);
    step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
    clearCounts(); sendFrame(HOME, 1'b0); idle(30, 1'b0);
    expectCounts("R3 ShiftDR ignored", 0, 0, 0, 0, 0);
    step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b0, 1'b0);

    // R4: illegal data pair 11
    clearCounts();
    for (int i = 0; i < FL; i++) step(1'b0, (i == 6 || i == 7) ? 1'b1 : frameBit(i, HOME));
    idle(30, 1'b0);
    expectCounts("R4 bad data pair", 0, 0, 0, 0, 0);

    // R4: bad stop pair 01
    clearCounts();
    for (int i = 0; i < FL; i++) step(1'b0, (i == FL - 1) ? 1'b1 : frameBit(i, HOME));
    idle(30, 1'b0);
    expectCounts("R4 bad stop", 0, 0, 0, 0, 0);

    // R3: leaving the parking states mid-frame drops it
    clearCounts();
    for (int i = 0; i < 12; i++) step(1'b0, frameBit(i, HOME));
    step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b0, 1'b0);
    for (int i = 12; i < FL; i++) step(1'b0, frameBit(i, HOME));
    idle(30, 1'b0);
    expectCounts("R3 mid-frame exit", 0, 0, 0, 0, 0);

    // R11: frame sent during acknowledgement is ignored
    clearCounts(); sendFrame(HOME, 1'b0); sendFrame(10'h155, 1'b0); idle(30, 1'b0);
    expectCounts("R11 tdi ignored during ack", 1, 0, 0, 0, FL);

    // R10: strapped to the global disconnect code
    myAddr = 10'h3FF;
    clearCounts(); sendFrame(10'h3FF, 1'b0); idle(30, 1'b0);
    expectCounts("R10 global precedence", 0, 1, 0, 0, 0);
    myAddr = HOME;

    // R9: test-sync in Pause-IR
    step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b1, 1'b0); step(1'b0, 1'b0);
    clearCounts(); sendFrame(10'h3FD, 1'b0); idle(30, 1'b0);
    expectCounts("R9 tsa in PauseIR", 0, 0, 0, 1, 0);

    // R1: five tms-high edges reach Test-Logic-Reset; frame then accepted with tms high
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
    clearCounts(); sendFrame(HOME, 1'b1); idle(30, 1'b1);
    expectCounts("R1 five-high to TLR", 1, 0, 0, 0, FL);

    // R12: pulse shape over the whole run
    chk(cMulti == 0, "R12 simultaneous commands", cMulti, 0);
    chk(cDouble == 0, "R12 command longer than one cycle", cDouble, 0);

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule